// File: doc/BRIEF.md
# Bus Wait-State Generator

This block holds a backplane cycle in wait while the board answers it. A short shift register is loaded, between bus strobes, with a pattern of "not ready" bits followed by "ready" bits. While a read or write strobe is active, the register moves one stage toward its output on each clock edge. The wait ends on the edge where the first "ready" bit reaches the output stage. The number of leading "not ready" bits sets the wait length. That number depends on the kind of access: a boot ROM read always takes a fixed, longer count. An I/O access or a DMA transfer takes a count of 2, 3 or 4 that is chosen through a small select input.

The wait request is always prepared inside the block. It reaches the shared ready line only when the global wait enable is set and the board is taking part in the current cycle. In every other case the line is released, so other boards are free to control it. The ready output is active low: a 0 holds the bus in wait, and a 1 releases it.

Top module: `waitStateGen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) discards any pending wait. In the cycle after reset, `readyOutN` is 1.
- R2: A boot ROM read (`accessType` = 0) with the wait enabled and the board selected holds `readyOutN` at 0 for exactly 5 clock cycles of active strobe.
- R3: An I/O access (`accessType` = 1) holds `readyOutN` at 0 for exactly 2 + `ioWaitSel` cycles of active strobe, for `ioWaitSel` values 0, 1 and 2.
- R4: The `ioWaitSel` value 3 gives the longest I/O and DMA wait, which is 4 cycles.
- R5: When `waitEnable` is 0, `readyOutN` is 1, even while a wait is pending inside the block.
- R6: When `boardSel` is 0, `readyOutN` is 1 in the same cycle.
- R7: The countdown keeps advancing while the wait is not driven. If the enable is raised part-way through an access, only the remaining cycles of that access are shown as wait.
- R8: Each clock edge without a strobe reloads the pattern. Every access, including one that follows another after a single idle cycle, therefore starts a fresh full-length wait.
- R9: Once ready has been reached, `readyOutN` stays 1 until the strobe drops.
- R10: A DMA cycle (`accessType` = 2) uses the same `ioWaitSel` lengths as an I/O access. The code 3 is handled the same way as an I/O access.
- R11: The wait length is taken from `accessType` and `ioWaitSel` at the last idle edge. A change to either input during the strobe has no effect on the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock; the register advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busStrobe | input | 1 | High while a bus read or write strobe is active |
| boardSel | input | 1 | High when this board answers the cycle (ROM read, I/O or DMA) |
| accessType | input | 2 | 0 = boot ROM read, 1 = I/O, 2 = DMA, 3 = treated as I/O |
| ioWaitSel | input | 2 | I/O and DMA wait choice: 0 = 2, 1 = 3, 2 or 3 = 4 cycles |
| waitEnable | input | 1 | Global enable for driving the wait onto the bus |
| readyOutN | output | 1 | Active-low ready line: 0 = wait, 1 = released |

## Verification
A stage of the register that is loaded wrongly, or that fails to shift, changes the number of cycles for which `readyOutN` stays low during one strobe. The error shows up at the port in the very first access of the affected type. A missed reload between strobes shows up as an immediate ready on the next access, in its first strobe cycle. A wrong gating term shows up combinationally, in the same cycle that `boardSel` or `waitEnable` changes.

// File: rtl/waitStatePkg.sv
package waitStatePkg;

  localparam int WAIT_LEN_W = 4;

  typedef enum logic [1:0] {
    ACC_ROM  = 2'd0,
    ACC_IO   = 2'd1,
    ACC_DMA  = 2'd2,
    ACC_RSVD = 2'd3
  } accKindT;

  typedef struct packed {
    logic                  load;
    logic                  shift;
    logic [WAIT_LEN_W-1:0] waitLen;
    logic                  drive;
  } waitCtrlT;

endpackage

// File: rtl/waitCtrl.sv
module waitCtrl
  import waitStatePkg::*;
#(
  parameter int ROM_WAIT     = 5,
  parameter int IO_WAIT_BASE = 2,
  parameter int IO_WAIT_MAX  = 4,
  parameter int SEL_W        = 2
) (
  input  logic             busStrobe,
  input  logic             boardSel,
  input  logic             waitEnable,
  input  logic [1:0]       accessType,
  input  logic [SEL_W-1:0] ioWaitSel,
  output waitCtrlT         ctrl
);

  localparam logic [WAIT_LEN_W-1:0] ROM_LEN  = WAIT_LEN_W'(ROM_WAIT);
  localparam logic [WAIT_LEN_W-1:0] IO_BASE  = WAIT_LEN_W'(IO_WAIT_BASE);
  localparam logic [WAIT_LEN_W-1:0] IO_LIMIT = WAIT_LEN_W'(IO_WAIT_MAX);

  accKindT kind;
  logic [WAIT_LEN_W-1:0] ioLen;

  always_comb begin
    kind  = accKindT'(accessType);
    ioLen = IO_BASE + WAIT_LEN_W'(ioWaitSel);
    if (ioLen > IO_LIMIT) ioLen = IO_LIMIT;
  end

  always_comb begin
    ctrl.load    = ~busStrobe;
    ctrl.shift   = busStrobe;
    ctrl.drive   = waitEnable & boardSel;
    unique case (kind)
      ACC_ROM: ctrl.waitLen = ROM_LEN;
      ACC_IO,
      ACC_DMA,
      ACC_RSVD: ctrl.waitLen = ioLen;
      default: ctrl.waitLen = ioLen;
    endcase
  end

endmodule

// File: rtl/waitShifter.sv
module waitShifter
  import waitStatePkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic     clk,
  input  logic     rst,
  input  waitCtrlT ctrl,
  output logic     readyStage
);

  logic [DEPTH-1:0] stage;
  logic [DEPTH-1:0] loadPattern;

  // stage k carries "ready" when at least waitLen shifts precede it
  for (genvar k = 0; k < DEPTH; k++) begin : g_pattern
    assign loadPattern[k] = (WAIT_LEN_W'(k) >= ctrl.waitLen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '1;
    end else if (ctrl.load) begin
      stage <= loadPattern;
    end else if (ctrl.shift) begin
      stage <= {1'b1, stage[DEPTH-1:1]};
    end
  end

  assign readyStage = stage[0];

endmodule

// File: rtl/waitStateGen.sv
module waitStateGen
  import waitStatePkg::*;
#(
  parameter int ROM_WAIT     = 5,
  parameter int IO_WAIT_BASE = 2,
  parameter int IO_WAIT_MAX  = 4,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busStrobe,
  input  logic             boardSel,
  input  logic [1:0]       accessType,
  input  logic [SEL_W-1:0] ioWaitSel,
  input  logic             waitEnable,
  output logic             readyOutN
);

  localparam int DEPTH = (ROM_WAIT > IO_WAIT_MAX) ? ROM_WAIT : IO_WAIT_MAX;

  waitCtrlT ctrl;
  logic     readyStage;

  waitCtrl #(
    .ROM_WAIT    (ROM_WAIT),
    .IO_WAIT_BASE(IO_WAIT_BASE),
    .IO_WAIT_MAX (IO_WAIT_MAX),
    .SEL_W       (SEL_W)
  ) i_ctrl (
    .busStrobe (busStrobe),
    .boardSel  (boardSel),
    .waitEnable(waitEnable),
    .accessType(accessType),
    .ioWaitSel (ioWaitSel),
    .ctrl      (ctrl)
  );

  waitShifter #(
    .DEPTH(DEPTH)
  ) i_shift (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .readyStage(readyStage)
  );

  assign readyOutN = ~(ctrl.drive & ~readyStage);

endmodule

// File: rtl/waitStateGen_chk.sv
module waitStateGen_chk (
  input logic clk,
  input logic rst,
  input logic busStrobe,
  input logic boardSel,
  input logic waitEnable,
  input logic readyOutN
);

  // R1
  reset_release_chk: assert property (@(posedge clk) rst |=> readyOutN);

  // R5
  disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
    !waitEnable |-> readyOutN);

  // R6
  unselected_release_chk: assert property (@(posedge clk) disable iff (rst)
    !boardSel |-> readyOutN);

  // R8
  fresh_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busStrobe) && !$past(rst) && waitEnable && boardSel) |-> !readyOutN);

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busStrobe && $past(busStrobe) && $past(readyOutN) && $past(waitEnable && boardSel)
     && waitEnable && boardSel) |-> readyOutN);

endmodule

bind waitStateGen waitStateGen_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .busStrobe (busStrobe),
  .boardSel  (boardSel),
  .waitEnable(waitEnable),
  .readyOutN (readyOutN)
);

// File: tb/test_waitStateGen.sv
module test_waitStateGen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busStrobe = 1'b0;
  logic       boardSel = 1'b0;
  logic [1:0] accessType = 2'd0;
  logic [1:0] ioWaitSel = 2'd0;
  logic       waitEnable = 1'b0;
  logic       readyOutN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  waitStateGen i_waitStateGen (
    .clk       (clk),
    .rst       (rst),
    .busStrobe (busStrobe),
    .boardSel  (boardSel),
    .accessType(accessType),
    .ioWaitSel (ioWaitSel),
    .waitEnable(waitEnable),
    .readyOutN (readyOutN)
  );

  function automatic int expLen(input logic [1:0] acc, input logic [1:0] sel);
    if (acc == 2'd0) return 5;
    if (sel >= 2'd2) return 4;
    return 2 + int'(sel);
  endfunction

  // reference: count strobe edges since the last idle edge
  int  mCnt = 0;
  int  mLen = 5;
  bit  mFromReset = 1'b1;
  always_ff @(posedge clk) begin
    if (rst) begin
      mFromReset <= 1'b1;
      mCnt <= 0;
    end else if (!busStrobe) begin
      mFromReset <= 1'b0;
      mCnt <= 0;
      mLen <= expLen(accessType, ioWaitSel);
    end else if (mCnt < 16) begin
      mCnt <= mCnt + 1;
    end
  end

  function automatic logic modelOut();
    logic ready;
    ready = mFromReset || (mCnt >= mLen);
    return ~(waitEnable & boardSel & ~ready);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: readyOutN=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkLen(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: wait length=%0d expected %0d", req, act, exp);
    end
  endtask

  // one idle cycle, then a strobe; returns cycles of wait seen
  task automatic access(input logic [1:0] acc, input logic [1:0] sel,
                        input string req, output int len);
    len = 0;
    @(negedge clk);
    busStrobe = 1'b0; accessType = acc; ioWaitSel = sel;
    waitEnable = 1'b1; boardSel = 1'b1;
    @(negedge clk);
    busStrobe = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #5;
      if (readyOutN) break;
      len++;
      @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      #5 check({req, "/R9"}, readyOutN, 1'b1);
    end
  endtask

  initial begin
    int len;
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #5 check("R1", readyOutN, 1'b1);

    // R1: reset in mid-wait releases the line
    @(negedge clk);
    busStrobe = 1'b0; boardSel = 1'b1; waitEnable = 1'b1; accessType = 2'd0;
    @(negedge clk); busStrobe = 1'b1;
    #5 check("R1 pre", readyOutN, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #5 check("R1", readyOutN, 1'b1);

    access(2'd0, 2'd0, "R2", len); checkLen("R2", len, 5);
    access(2'd1, 2'd0, "R3", len); checkLen("R3 sel0", len, 2);
    access(2'd1, 2'd1, "R3", len); checkLen("R3 sel1", len, 3);
    access(2'd1, 2'd2, "R3", len); checkLen("R3 sel2", len, 4);
    access(2'd1, 2'd3, "R4", len); checkLen("R4", len, 4);
    access(2'd2, 2'd1, "R10", len); checkLen("R10 dma", len, 3);
    access(2'd3, 2'd0, "R10", len); checkLen("R10 code3", len, 2);
    access(2'd0, 2'd0, "R8", len); checkLen("R8 first", len, 5);
    access(2'd0, 2'd0, "R8", len); checkLen("R8 second", len, 5);

    // R5 and R7: pending wait hidden, then shown for the remainder
    @(negedge clk);
    busStrobe = 1'b0; accessType = 2'd0; waitEnable = 1'b0; boardSel = 1'b1;
    @(negedge clk); busStrobe = 1'b1;
    #5 check("R5", readyOutN, 1'b1);
    @(negedge clk);
    #5 check("R5", readyOutN, 1'b1);
    @(negedge clk); waitEnable = 1'b1;
    len = 0;
    for (int i = 0; i < 10; i++) begin
      #5;
      if (readyOutN) break;
      len++;
      @(negedge clk);
    end
    checkLen("R7", len, 3);

    // R6: deselect releases in the same cycle
    @(negedge clk); busStrobe = 1'b0;
    @(negedge clk); busStrobe = 1'b1;
    #5 check("R6 pre", readyOutN, 1'b0);
    boardSel = 1'b0;
    #2 check("R6", readyOutN, 1'b1);
    boardSel = 1'b1;

    // R11: access kind changed during strobe has no effect
    @(negedge clk);
    busStrobe = 1'b0; accessType = 2'd1; ioWaitSel = 2'd0;
    @(negedge clk); busStrobe = 1'b1; accessType = 2'd0; ioWaitSel = 2'd2;
    len = 0;
    for (int i = 0; i < 10; i++) begin
      #5;
      if (readyOutN) break;
      len++;
      @(negedge clk);
    end
    checkLen("R11", len, 2);

    // random phase against the reference model
    @(negedge clk); busStrobe = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rst        = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 3) == 0) busStrobe = ~busStrobe;
      boardSel   = ($urandom_range(0, 7) != 0);
      waitEnable = ($urandom_range(0, 7) != 0);
      accessType = 2'($urandom_range(0, 3));
      ioWaitSel  = 2'($urandom_range(0, 3));
      #5;
      if (rst) continue;
      if (!waitEnable)      check("R5", readyOutN, modelOut());
      else if (!boardSel)   check("R6", readyOutN, modelOut());
      else if (mFromReset)  check("R1", readyOutN, modelOut());
      else if (mLen == 5)   check("R2", readyOutN, modelOut());
      else                  check("R3", readyOutN, modelOut());
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule